// File: doc/BRIEF.md
# Saturating SIMD Byte ALU with Flag Registers

This block is a sixteen-lane arithmetic unit that works on byte lanes of 128-bit vectors. Each lane computes minimum, maximum, absolute value, negation, addition, subtraction or a three-input range clip. Every result is clamped to the byte range of the selected signedness. The second operand is either a vector or an 8-bit immediate copied into every lane. All lanes are computed in parallel, and the result vector is captured on the clock edge on which the issue strobe is high.

Each operation also produces a sign flag and a zero flag for every lane. A 3-bit destination field chooses which of four internal flag registers receives them. A destination value of four or more suppresses the flag write and leaves the result write in place. Any flag register can be read as a 32-bit word through a combinational read port.

Top module: `sat_byte_simd_alu`

## Requirements
- R1: After reset, `result` is zero and all four flag words read zero.
- R2: While `issue` is low, neither `result` nor any flag word changes, whatever the other inputs do.
- R3: The opcode has fields [5] immediate select, [4] unsigned select, [3] ignored and [2:0] operation. With opcode[5]=1 and a non-clip operation, `imm` replaces every lane of operand 2 and `src_b` has no effect.
- R4: The operation codes are 0 min, 1 max, 2 abs, 3 neg, 4 add (a+b), 5 sub (a-b), and 6 or 7 clip. With opcode[4]=0, lanes are sign-extended, the result clamps to -128..127, and the sign flag is 1 exactly when the unclamped result is negative.
- R5: With opcode[4]=1 and operation codes 0, 1, 2, 4 or 5, lanes are zero-extended, the result clamps to 0..255, and the sign flag is 1 exactly when clamping took place.
- R6: Negation is always signed, whatever opcode[4] holds, so -(-128) gives 127. Unsigned abs returns the operand unchanged with the sign flag clear.
- R7: Clip treats `src_a`, `src_b` and `src_c` as signed bytes and ignores opcode[5:3]. The low and high ends are the smaller and larger of b and c. The sign flag is 1 if b >= c. The result is the low end if a <= low, otherwise the high end if a >= high, otherwise a. Reaching either end also sets the sign flag.
- R8: The zero flag of a lane is 1 exactly when the final clamped byte of that lane is zero.
- R9: The flag word is {zero flags, sign flags}: bits 15:0 hold the sign flags and bits 31:16 the zero flags, with lane i at bit i and bit 16+i. `flag_rd_word` shows the register chosen by `flag_rd_sel` in the same cycle.
- R10: When `flag_dst` is 4..7 on issue, all flag registers keep their values and `result` is still written.
- R11: On issue with `flag_dst` 0..3, `result` and the selected flag register both take their new values on the same clock edge, and the other flag registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute the presented operation on this edge |
| opcode | input | 6 | Immediate select, unsigned select, operation |
| src_a | input | 128 | Operand 1 vector, lane i at bits 8i+7:8i |
| src_b | input | 128 | Operand 2 vector, low clip bound candidate |
| src_c | input | 128 | Second clip bound candidate |
| imm | input | 8 | Immediate copied into every lane of operand 2 |
| flag_dst | input | 3 | Flag register index 0..3; 4..7 means no flag write |
| flag_rd_sel | input | 2 | Flag register shown on the read port |
| result | output | 128 | Registered saturated result vector |
| flag_rd_word | output | 32 | Selected flag register {zero flags, sign flags} |

## Verification
The result write and the flag write take effect on the same edge. A flag write can also be suppressed while the result is still written. The bench issues operations with every destination code, including the suppressing ones. After each issue it checks the new result together with all four flag words against a shadow copy, so any write that lands late, on the wrong register or when it should have been suppressed is caught. Random operations are mixed with directed saturation and clip-endpoint cases, and idle cycles with changing inputs check that nothing moves without issue.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [2:0] {
    OP_MIN      = 3'd0,
    OP_MAX      = 3'd1,
    OP_ABS      = 3'd2,
    OP_NEG      = 3'd3,
    OP_ADD      = 3'd4,
    OP_SUB      = 3'd5,
    OP_CLIP     = 3'd6,
    OP_CLIP_ALT = 3'd7
  } alu_op_e;

  localparam int OPC_W       = 6;
  localparam int OPC_IMM_BIT = 5;
  localparam int OPC_UNS_BIT = 4;

endpackage

// File: rtl/sba_decode.sv
module sba_decode
  import sba_pkg::*;
#(
  parameter int FDST_W        = 3,
  parameter int NUM_FLAG_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_FLAG_REGS)
) (
  input  logic              issue,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FDST_W-1:0] flag_dst,
  output alu_op_e           op,
  output logic              signed_mode,
  output logic              use_imm,
  output logic              flag_we,
  output logic [IDX_W-1:0]  flag_idx
);

  localparam logic [FDST_W:0] NREG_V = (FDST_W+1)'(NUM_FLAG_REGS);

  logic is_clip;
  logic unused_opc_bit;

  assign unused_opc_bit = opcode[3];

  always_comb begin
    op          = alu_op_e'(opcode[2:0]);
    is_clip     = (opcode[2:1] == 2'b11);
    // negation has no unsigned form; clip is signed by definition
    signed_mode = !opcode[OPC_UNS_BIT] || (op == OP_NEG) || is_clip;
    use_imm     = opcode[OPC_IMM_BIT] && !is_clip;
    flag_we     = issue && ({1'b0, flag_dst} < NREG_V);
    flag_idx    = flag_dst[IDX_W-1:0];
  end

endmodule

// File: rtl/sba_lane.sv
module sba_lane
  import sba_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic           signed_mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  output logic [W-1:0]   res,
  output logic           sf,
  output logic           zf
);

  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] S_MAX_X = {{3{1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] S_MIN_X = {{3{1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [XW-1:0] U_MAX_X = {2'b00, {W{1'b1}}};

  logic signed [XW-1:0] sa, sb, sc;
  logic signed [XW-1:0] ea, eb;
  logic signed [XW-1:0] raw;
  logic signed [XW-1:0] lo, hi;

  always_comb begin
    sa = {{2{a[W-1]}}, a};
    sb = {{2{b[W-1]}}, b};
    sc = {{2{c[W-1]}}, c};
    ea = signed_mode ? sa : {2'b00, a};
    eb = signed_mode ? sb : {2'b00, b};

    unique case (op)
      OP_MIN:  raw = (ea < eb) ? ea : eb;
      OP_MAX:  raw = (ea > eb) ? ea : eb;
      OP_ABS:  raw = ea[XW-1] ? -ea : ea;
      OP_NEG:  raw = -ea;
      OP_ADD:  raw = ea + eb;
      OP_SUB:  raw = ea - eb;
      default: raw = ea;
    endcase

    lo  = sb;
    hi  = sc;
    res = '0;
    sf  = 1'b0;

    if (op == OP_CLIP || op == OP_CLIP_ALT) begin
      if (sb < sc) begin
        lo = sb;
        hi = sc;
      end else begin
        lo = sc;
        hi = sb;
        sf = 1'b1;
      end
      res = a;
      if (sa <= lo) begin
        res = lo[W-1:0];
        sf  = 1'b1;
      end
      if (sa >= hi) begin
        res = hi[W-1:0];
        sf  = 1'b1;
      end
    end else if (signed_mode) begin
      sf = raw[XW-1];
      if (raw > S_MAX_X)      res = S_MAX_X[W-1:0];
      else if (raw < S_MIN_X) res = S_MIN_X[W-1:0];
      else                    res = raw[W-1:0];
    end else begin
      if (raw[XW-1]) begin
        res = '0;
        sf  = 1'b1;
      end else if (raw > U_MAX_X) begin
        res = U_MAX_X[W-1:0];
        sf  = 1'b1;
      end else begin
        res = raw[W-1:0];
      end
    end

    zf = (res == '0);
  end

endmodule

// File: rtl/sba_flag_bank.sv
module sba_flag_bank #(
  parameter int LANES         = 16,
  parameter int NUM_FLAG_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_FLAG_REGS),
  localparam int FW           = 2 * LANES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [LANES-1:0]                  sf_vec,
  input  logic [LANES-1:0]                  zf_vec,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [FW-1:0]                     rd_word,
  output logic [NUM_FLAG_REGS-1:0][FW-1:0]  words
);

  logic [NUM_FLAG_REGS-1:0][FW-1:0] regs_d, regs_q;

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[wr_idx] = {zf_vec, sf_vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_word = regs_q[rd_idx];
  assign words   = regs_q;

endmodule

// File: rtl/sat_byte_simd_alu.sv
module sat_byte_simd_alu
  import sba_pkg::*;
#(
  parameter int LANES         = 16,
  parameter int LANE_W        = 8,
  parameter int NUM_FLAG_REGS = 4,
  parameter int FDST_W        = 3,
  localparam int VW           = LANES * LANE_W,
  localparam int FW           = 2 * LANES,
  localparam int IDX_W        = $clog2(NUM_FLAG_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [VW-1:0]     src_a,
  input  logic [VW-1:0]     src_b,
  input  logic [VW-1:0]     src_c,
  input  logic [LANE_W-1:0] imm,
  input  logic [FDST_W-1:0] flag_dst,
  input  logic [IDX_W-1:0]  flag_rd_sel,
  output logic [VW-1:0]     result,
  output logic [FW-1:0]     flag_rd_word
);

  alu_op_e          op;
  logic             signed_mode;
  logic             use_imm;
  logic             flag_we;
  logic [IDX_W-1:0] flag_idx;

  logic [VW-1:0]    opnd_b;
  logic [VW-1:0]    lane_res;
  logic [LANES-1:0] sf_vec, zf_vec;
  logic [VW-1:0]    result_d, result_q;
  logic [NUM_FLAG_REGS-1:0][FW-1:0] flag_words;

  sba_decode #(
    .FDST_W       (FDST_W),
    .NUM_FLAG_REGS(NUM_FLAG_REGS)
  ) u_dec (
    .issue      (issue),
    .opcode     (opcode),
    .flag_dst   (flag_dst),
    .op         (op),
    .signed_mode(signed_mode),
    .use_imm    (use_imm),
    .flag_we    (flag_we),
    .flag_idx   (flag_idx)
  );

  assign opnd_b = use_imm ? {LANES{imm}} : src_b;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sba_lane #(.W(LANE_W)) u_lane (
      .op         (op),
      .signed_mode(signed_mode),
      .a          (src_a[i*LANE_W +: LANE_W]),
      .b          (opnd_b[i*LANE_W +: LANE_W]),
      .c          (src_c[i*LANE_W +: LANE_W]),
      .res        (lane_res[i*LANE_W +: LANE_W]),
      .sf         (sf_vec[i]),
      .zf         (zf_vec[i])
    );
  end

  always_comb begin
    result_d = result_q;
    if (issue) result_d = lane_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  assign result = result_q;

  sba_flag_bank #(
    .LANES        (LANES),
    .NUM_FLAG_REGS(NUM_FLAG_REGS)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (flag_we),
    .wr_idx (flag_idx),
    .sf_vec (sf_vec),
    .zf_vec (zf_vec),
    .rd_idx (flag_rd_sel),
    .rd_word(flag_rd_word),
    .words  (flag_words)
  );

endmodule

// File: rtl/sba_alu_chk.sv
module sba_alu_chk
  import sba_pkg::*;
#(
  parameter int LANES         = 16,
  parameter int LANE_W        = 8,
  parameter int NUM_FLAG_REGS = 4,
  parameter int FDST_W        = 3,
  localparam int VW           = LANES * LANE_W,
  localparam int FW           = 2 * LANES,
  localparam int IDX_W        = $clog2(NUM_FLAG_REGS)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             issue,
  input logic [OPC_W-1:0]                 opcode,
  input logic [VW-1:0]                    src_b,
  input logic [VW-1:0]                    src_c,
  input logic [FDST_W-1:0]                flag_dst,
  input logic [VW-1:0]                    result,
  input logic [NUM_FLAG_REGS-1:0][FW-1:0] flag_words
);

  localparam logic [FDST_W:0] NREG_V = (FDST_W+1)'(NUM_FLAG_REGS);

  logic             wr_q, clip_q;
  logic [IDX_W-1:0] dst_q;
  logic [VW-1:0]    b_q, c_q;
  logic [LANES-1:0] zmask, lane_ok;
  logic             dst_valid, is_clip;
  logic [3:0]       unused_opc;

  assign unused_opc = opcode[5:2];
  assign is_clip    = (opcode[2:1] == 2'b11);
  assign dst_valid  = ({1'b0, flag_dst} < NREG_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      clip_q <= 1'b0;
      dst_q  <= '0;
      b_q    <= '0;
      c_q    <= '0;
    end else begin
      wr_q   <= issue && dst_valid;
      clip_q <= issue && is_clip;
      dst_q  <= flag_dst[IDX_W-1:0];
      b_q    <= src_b;
      c_q    <= src_c;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic signed [LANE_W-1:0] rv, bv, cv, lo, hi;
      rv = result[i*LANE_W +: LANE_W];
      bv = b_q[i*LANE_W +: LANE_W];
      cv = c_q[i*LANE_W +: LANE_W];
      lo = (bv < cv) ? bv : cv;
      hi = (bv < cv) ? cv : bv;
      zmask[i]   = (rv == '0);
      lane_ok[i] = (rv >= lo) && (rv <= hi);
    end
  end

  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(result));

  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(flag_words));

  a_r10_no_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !dst_valid) |=> $stable(flag_words));

  a_r8_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (flag_words[dst_q][FW-1:LANES] == zmask));

  a_r7_clip_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    clip_q |-> (lane_ok == {LANES{1'b1}}));

endmodule

bind sat_byte_simd_alu sba_alu_chk #(
  .LANES        (LANES),
  .LANE_W       (LANE_W),
  .NUM_FLAG_REGS(NUM_FLAG_REGS),
  .FDST_W       (FDST_W)
) u_chk (.*);

// File: tb/sat_byte_simd_alu_test.sv
`timescale 1ns/1ps
module sat_byte_simd_alu_test;

  logic         clk;
  logic         rst_n;
  logic         issue;
  logic [5:0]   opcode;
  logic [127:0] src_a, src_b, src_c;
  logic [7:0]   imm;
  logic [2:0]   flag_dst;
  logic [1:0]   flag_rd_sel;
  logic [127:0] result;
  logic [31:0]  flag_rd_word;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0]  shadow [4];
  logic [127:0] exp_result;

  sat_byte_simd_alu uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
    .flag_dst(flag_dst), .flag_rd_sel(flag_rd_sel),
    .result(result), .flag_rd_word(flag_rd_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] ref_lane(logic [5:0] opc, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    int x, y, z, lo, hi, r;
    logic sf, sg;
    if (opc[2:1] == 2'b11) begin
      x = int'($signed(a)); y = int'($signed(b)); z = int'($signed(c));
      sf = !(y < z);
      lo = (y < z) ? y : z;
      hi = (y < z) ? z : y;
      r = x;
      if (x <= lo) begin r = lo; sf = 1'b1; end
      if (x >= hi) begin r = hi; sf = 1'b1; end
    end else begin
      sg = !opc[4] || (opc[2:0] == 3'd3);
      x = sg ? int'($signed(a)) : int'(a);
      y = sg ? int'($signed(b)) : int'(b);
      case (opc[2:0])
        3'd0: r = (x < y) ? x : y;
        3'd1: r = (x > y) ? x : y;
        3'd2: r = (x < 0) ? -x : x;
        3'd3: r = -x;
        3'd4: r = x + y;
        default: r = x - y;
      endcase
      if (sg) begin
        sf = (r < 0);
        if (r > 127) r = 127;
        if (r < -128) r = -128;
      end else begin
        sf = 1'b0;
        if (r < 0)   begin r = 0;   sf = 1'b1; end
        if (r > 255) begin r = 255; sf = 1'b1; end
      end
    end
    return {sf, (r[7:0] == 8'h00), r[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    for (int k = 0; k < 4; k++) begin
      flag_rd_sel = k[1:0];
      #1;
      chk($sformatf("%s R9 flag word %0d", tag, k), {96'b0, flag_rd_word}, {96'b0, shadow[k]});
    end
  endtask

  task automatic run_op(input logic [5:0] opc, input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] c, input logic [7:0] im, input logic [2:0] dst,
                        input string tag);
    logic [15:0] sfv, zfv;
    logic [9:0]  lr;
    logic [7:0]  bop;
    for (int i = 0; i < 16; i++) begin
      bop = (opc[5] && opc[2:1] != 2'b11) ? im : b[i*8 +: 8];
      lr  = ref_lane(opc, a[i*8 +: 8], bop, c[i*8 +: 8]);
      sfv[i] = lr[9];
      zfv[i] = lr[8];
      exp_result[i*8 +: 8] = lr[7:0];
    end
    @(negedge clk);
    opcode = opc; src_a = a; src_b = b; src_c = c; imm = im; flag_dst = dst; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    if (dst < 3'd4) shadow[dst[1:0]] = {zfv, sfv};
    chk({tag, " R11 result"}, result, exp_result);
    chk_flags(tag);
  endtask

  task automatic idle_check();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      opcode = 6'($urandom); src_a = {4{$urandom}}; src_b = {4{$urandom}};
      src_c = {4{$urandom}}; imm = 8'($urandom); flag_dst = 3'($urandom);
    end
    @(negedge clk);
    chk("R2 result held while idle", result, exp_result);
    chk_flags("R2 idle");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; issue = 1'b0; opcode = '0; src_a = '0; src_b = '0; src_c = '0;
    imm = '0; flag_dst = 3'd7; flag_rd_sel = '0;
    for (int k = 0; k < 4; k++) shadow[k] = '0;
    exp_result = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset result", result, 128'b0);
    chk_flags("R1 reset");

    // R4 signed saturation at both ends
    run_op(6'b000100, {16{8'h7F}}, {16{8'h01}}, '0, 8'h00, 3'd0, "R4 signed add high clamp");
    run_op(6'b000101, {16{8'h80}}, {16{8'h01}}, '0, 8'h00, 3'd1, "R4 signed sub low clamp");
    // R5 unsigned saturation
    run_op(6'b010100, {16{8'hC8}}, {16{8'h64}}, '0, 8'h00, 3'd2, "R5 unsigned add clamp");
    run_op(6'b010101, {16{8'h05}}, {16{8'h0A}}, '0, 8'h00, 3'd3, "R5 R8 unsigned sub to zero");
    // R6 neg and unsigned abs
    run_op(6'b010011, {16{8'h80}}, '0, '0, 8'h00, 3'd0, "R6 neg of -128 ignores unsigned bit");
    run_op(6'b010010, {16{8'h90}}, '0, '0, 8'h00, 3'd1, "R6 unsigned abs passthrough");
    // R3 immediate replaces src_b
    run_op(6'b100000, {8{16'h10F0}}, {16{8'h00}}, '0, 8'h20, 3'd2, "R3 signed min with immediate");
    run_op(6'b110001, {8{16'h10F0}}, {16{8'hFF}}, '0, 8'h20, 3'd3, "R3 unsigned max with immediate");
    // R7 clip: proper, reversed, equal endpoints, at endpoints
    run_op(6'b000110, {4{32'h05_F0_7F_80}}, {16{8'hF6}}, {16{8'h0A}}, 8'h00, 3'd0, "R7 clip proper range");
    run_op(6'b110111, {4{32'h05_0A_F6_00}}, {16{8'h0A}}, {16{8'hF6}}, 8'h55, 3'd1, "R7 clip reversed range");
    run_op(6'b000110, {4{32'h05_00_7F_81}}, {16{8'h00}}, {16{8'h00}}, 8'h00, 3'd2, "R7 R8 clip empty range");
    // R10 suppressed flag write, result still written
    run_op(6'b000100, {16{8'h01}}, {16{8'h02}}, '0, 8'h00, 3'd7, "R10 dst 7 suppresses flags");
    run_op(6'b010101, {16{8'h00}}, {16{8'h01}}, '0, 8'h00, 3'd4, "R10 dst 4 suppresses flags");
    idle_check();

    for (int t = 0; t < 400; t++) begin
      logic [127:0] ra, rb, rc;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rc = {$urandom, $urandom, $urandom, $urandom};
      if (t % 5 == 0) rb = {16{8'h80}};
      if (t % 7 == 0) ra = {16{8'h7F}};
      run_op(6'($urandom), ra, rb, rc, 8'($urandom), 3'($urandom),
             $sformatf("R4 R5 R11 random op %0d", t));
      if (t % 50 == 0) idle_check();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule